// File: doc/BRIEF.md
# Serial Port Data Status Flags

This block keeps the per-channel receive "data ready" and transmit "holding empty" flags of a two-channel synchronous serial audio port. It also raises the port's receive and transmit interrupt lines. Each channel either buffers its words through a FIFO or bypasses it with a single holding register. The flag for a channel takes its set and clear events from whichever path that channel's FIFO-enable bit selects. The FIFOs, the shifter and the framing logic sit outside and report to this block through single-cycle strobes and level indications.

Channel 0 works in every mode. Channel 1 takes part only when two-channel mode is on. Otherwise its flags stay at 0 and it cannot raise an interrupt. The flags are registered one cycle after the event that moves them. The interrupt lines are registered one cycle after the flags, or after the level inputs they sample.

Top module: `serial_status_flags`

## Requirements
- R1: Power-on reset (`por_n` low, asynchronous) and block reset (`blk_rst` high, synchronous, overriding every other input) drive all four flags and both interrupt lines to 0.
- R2: With a channel's receive FIFO enabled (`rx_fifo_en[c]`=1), `rx_ready[c]` becomes 1 the cycle after `rx_fifo_load[c]`. It becomes 0 the cycle after `rx_fifo_empty[c]` is seen without a load, and otherwise holds.
- R3: With the receive FIFO disabled, `rx_ready[c]` becomes 1 the cycle after `rx_hold_load[c]`. It becomes 0 the cycle after `rx_hold_read[c]` without a load, and otherwise holds.
- R4: With a channel's transmit FIFO enabled, `tx_empty[c]` equals the inverse of `tx_fifo_full[c]` sampled one cycle earlier.
- R5: With the transmit FIFO disabled, `tx_empty[c]` becomes 1 the cycle after `tx_xfer[c]`. It becomes 0 the cycle after `tx_hold_write[c]` without a transfer, and otherwise holds.
- R6: When a set event and a clear event of the selected path arrive in the same cycle, the flag becomes 1.
- R7: When `two_ch_en` is 0, `rx_ready[1]` and `tx_empty[1]` are 0 the next cycle and channel 1 contributes nothing to either interrupt. Channel 0 is unaffected by `two_ch_en`.
- R8: `rx_irq` is 1 in a cycle exactly when, in the previous cycle, `rx_ie` was 1 and some active channel c had one of these: FIFO enabled with `rx_wm_ie[c]` and `rx_fifo_wm[c]` both 1, or FIFO disabled with `rx_rdy_ie[c]` and `rx_ready[c]` both 1.
- R9: `tx_irq` is 1 in a cycle exactly when, in the previous cycle, `tx_ie` was 1 and some active channel c had `tx_emp_ie[c]`=1 together with either `tx_empty[c]`=1 or (transmit FIFO disabled and `tx_xfer[c]`=1).
- R10: A flag change reaches an interrupt line one further cycle later, so an event reaches the flag after one clock and the interrupt after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| blk_rst | input | 1 | Block reset, synchronous, active high |
| two_ch_en | input | 1 | Two-channel mode |
| rx_fifo_en | input | 2 | Receive FIFO enable per channel |
| tx_fifo_en | input | 2 | Transmit FIFO enable per channel |
| rx_fifo_load | input | 2 | Receive FIFO took a new word (strobe) |
| rx_fifo_empty | input | 2 | Receive FIFO is empty (level) |
| rx_fifo_wm | input | 2 | Receive FIFO full/watermark reached (level) |
| rx_hold_load | input | 2 | Receive holding register loaded (strobe) |
| rx_hold_read | input | 2 | Receive holding register read by software (strobe) |
| tx_fifo_full | input | 2 | Transmit FIFO is full (level) |
| tx_hold_write | input | 2 | Transmit holding register written by software (strobe) |
| tx_xfer | input | 2 | Transmit holding word moved to the shifter (strobe) |
| rx_ie | input | 1 | Global receive interrupt enable |
| rx_wm_ie | input | 2 | Per-channel watermark interrupt enable |
| rx_rdy_ie | input | 2 | Per-channel receive-ready interrupt enable |
| tx_ie | input | 1 | Global transmit interrupt enable |
| tx_emp_ie | input | 2 | Per-channel transmit-empty interrupt enable |
| rx_ready | output | 2 | Receive data ready flags |
| tx_empty | output | 2 | Transmit holding empty flags |
| rx_irq | output | 1 | Receive interrupt, registered level |
| tx_irq | output | 1 | Transmit interrupt, registered level |

## Verification
The assertions assume that every strobe input lasts one clock and is stable around the edge. They also assume that `blk_rst` is sampled synchronously, so that a flag seen one cycle after an event reflects only that cycle's inputs. The stimulus meets this by changing every input a fixed delay after the rising edge. It draws the strobes, levels and enables independently from a seeded generator, so set and clear events of one path often coincide and the mode bits move between cycles. Directed sequences add the coincident-event and single-channel cases, and block and power-on resets are injected in the middle of the run.

// File: rtl/serial_status_pkg.sv
package serial_status_pkg;
    localparam int NUM_CH = 2;

    typedef struct packed {
        logic [NUM_CH-1:0] rdy;
        logic [NUM_CH-1:0] emp;
        logic              rx_irq;
        logic              tx_irq;
    } flag_state_t;

    localparam flag_state_t FLAG_RESET = '{rdy: '0, emp: '0, rx_irq: 1'b0, tx_irq: 1'b0};
endpackage

// File: rtl/ssf_chan.sv
module ssf_chan (
    input  logic act,
    input  logic rx_fen,
    input  logic tx_fen,
    input  logic fifo_load,
    input  logic fifo_empty,
    input  logic fifo_wm,
    input  logic hold_load,
    input  logic hold_read,
    input  logic fifo_full,
    input  logic hold_write,
    input  logic xfer,
    input  logic wm_ie,
    input  logic rdy_ie,
    input  logic emp_ie,
    input  logic rdy_q,
    input  logic emp_q,
    output logic rdy_d,
    output logic emp_d,
    output logic rx_req,
    output logic tx_req
);
    logic rx_set, rx_clr, tx_set, tx_clr;

    always_comb begin
        rx_set = rx_fen ? fifo_load  : hold_load;
        rx_clr = rx_fen ? fifo_empty : hold_read;
        tx_set = tx_fen ? 1'b0       : xfer;
        tx_clr = tx_fen ? 1'b0       : hold_write;

        rdy_d = act & (rx_set | (rdy_q & ~rx_clr));
        if (tx_fen) begin
            emp_d = act & ~fifo_full;
        end else begin
            emp_d = act & (tx_set | (emp_q & ~tx_clr));
        end

        rx_req = act & (rx_fen ? (wm_ie & fifo_wm) : (rdy_ie & rdy_q));
        tx_req = act & emp_ie & (emp_q | (~tx_fen & xfer));
    end
endmodule

// File: rtl/ssf_irq.sv
module ssf_irq #(
    parameter int N = 2
) (
    input  logic         rx_ie,
    input  logic         tx_ie,
    input  logic [N-1:0] rx_req,
    input  logic [N-1:0] tx_req,
    output logic         rx_irq_d,
    output logic         tx_irq_d
);
    always_comb begin
        rx_irq_d = rx_ie & (|rx_req);
        tx_irq_d = tx_ie & (|tx_req);
    end
endmodule

// File: rtl/serial_status_flags.sv
module serial_status_flags
    import serial_status_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              blk_rst,
    input  logic              two_ch_en,
    input  logic [NUM_CH-1:0] rx_fifo_en,
    input  logic [NUM_CH-1:0] tx_fifo_en,
    input  logic [NUM_CH-1:0] rx_fifo_load,
    input  logic [NUM_CH-1:0] rx_fifo_empty,
    input  logic [NUM_CH-1:0] rx_fifo_wm,
    input  logic [NUM_CH-1:0] rx_hold_load,
    input  logic [NUM_CH-1:0] rx_hold_read,
    input  logic [NUM_CH-1:0] tx_fifo_full,
    input  logic [NUM_CH-1:0] tx_hold_write,
    input  logic [NUM_CH-1:0] tx_xfer,
    input  logic              rx_ie,
    input  logic [NUM_CH-1:0] rx_wm_ie,
    input  logic [NUM_CH-1:0] rx_rdy_ie,
    input  logic              tx_ie,
    input  logic [NUM_CH-1:0] tx_emp_ie,
    output logic [NUM_CH-1:0] rx_ready,
    output logic [NUM_CH-1:0] tx_empty,
    output logic              rx_irq,
    output logic              tx_irq
);
    flag_state_t       st_d, st_q;
    logic [NUM_CH-1:0] act, rdy_n, emp_n, rx_req, tx_req;
    logic              rx_irq_n, tx_irq_n;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign act[c] = (c == 0) ? 1'b1 : two_ch_en;

        ssf_chan u_chan (
            .act        (act[c]),
            .rx_fen     (rx_fifo_en[c]),
            .tx_fen     (tx_fifo_en[c]),
            .fifo_load  (rx_fifo_load[c]),
            .fifo_empty (rx_fifo_empty[c]),
            .fifo_wm    (rx_fifo_wm[c]),
            .hold_load  (rx_hold_load[c]),
            .hold_read  (rx_hold_read[c]),
            .fifo_full  (tx_fifo_full[c]),
            .hold_write (tx_hold_write[c]),
            .xfer       (tx_xfer[c]),
            .wm_ie      (rx_wm_ie[c]),
            .rdy_ie     (rx_rdy_ie[c]),
            .emp_ie     (tx_emp_ie[c]),
            .rdy_q      (st_q.rdy[c]),
            .emp_q      (st_q.emp[c]),
            .rdy_d      (rdy_n[c]),
            .emp_d      (emp_n[c]),
            .rx_req     (rx_req[c]),
            .tx_req     (tx_req[c])
        );
    end

    ssf_irq #(.N(NUM_CH)) u_irq (
        .rx_ie    (rx_ie),
        .tx_ie    (tx_ie),
        .rx_req   (rx_req),
        .tx_req   (tx_req),
        .rx_irq_d (rx_irq_n),
        .tx_irq_d (tx_irq_n)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rdy    = rdy_n;
        st_d.emp    = emp_n;
        st_d.rx_irq = rx_irq_n;
        st_d.tx_irq = tx_irq_n;
        if (blk_rst) begin
            st_d = FLAG_RESET;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= FLAG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_ready = st_q.rdy;
    assign tx_empty = st_q.emp;
    assign rx_irq   = st_q.rx_irq;
    assign tx_irq   = st_q.tx_irq;

    // R1
    blk_reset_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
        blk_rst |=> (rx_ready == '0 && tx_empty == '0 && !rx_irq && !tx_irq));

    // R7
    single_ch_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        !two_ch_en |=> (!rx_ready[1] && !tx_empty[1]));

    // R6
    rx_set_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!blk_rst && !rx_fifo_en[0] && rx_hold_load[0] && rx_hold_read[0]) |=> rx_ready[0]);

    // R3
    rx_read_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!blk_rst && !rx_fifo_en[0] && rx_hold_read[0] && !rx_hold_load[0]) |=> !rx_ready[0]);

    // R2
    rx_fifo_load_sets_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!blk_rst && rx_fifo_en[0] && rx_fifo_load[0]) |=> rx_ready[0]);

    // R4
    tx_full_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
        (tx_fifo_en[0] && tx_fifo_full[0]) |=> !tx_empty[0]);

    // R5
    tx_xfer_sets_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!blk_rst && !tx_fifo_en[0] && tx_xfer[0]) |=> tx_empty[0]);

    // R8
    rx_irq_global_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rx_ie |=> !rx_irq);

    // R9
    tx_irq_global_chk: assert property (@(posedge clk) disable iff (!por_n)
        !tx_ie |=> !tx_irq);
endmodule

// File: tb/serial_status_flags_bench.sv
module serial_status_flags_bench;
    logic       clk = 1'b0;
    logic       por_n = 1'b0, blk_rst = 1'b0, two_ch_en = 1'b0;
    logic [1:0] rx_fifo_en = '0, tx_fifo_en = '0, rx_fifo_load = '0, rx_fifo_empty = '0;
    logic [1:0] rx_fifo_wm = '0, rx_hold_load = '0, rx_hold_read = '0, tx_fifo_full = '0;
    logic [1:0] tx_hold_write = '0, tx_xfer = '0, rx_wm_ie = '0, rx_rdy_ie = '0, tx_emp_ie = '0;
    logic       rx_ie = 1'b0, tx_ie = 1'b0;
    logic [1:0] rx_ready, tx_empty;
    logic       rx_irq, tx_irq;

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model state (expected outputs)
    logic [1:0] m_rdy = '0, m_emp = '0;
    logic       m_rxi = 1'b0, m_txi = 1'b0;
    string      tag_rdy [2];
    string      tag_emp [2];

    always #4 clk = ~clk;

    serial_status_flags u_serial_status_flags (
        .clk(clk), .por_n(por_n), .blk_rst(blk_rst), .two_ch_en(two_ch_en),
        .rx_fifo_en(rx_fifo_en), .tx_fifo_en(tx_fifo_en), .rx_fifo_load(rx_fifo_load),
        .rx_fifo_empty(rx_fifo_empty), .rx_fifo_wm(rx_fifo_wm), .rx_hold_load(rx_hold_load),
        .rx_hold_read(rx_hold_read), .tx_fifo_full(tx_fifo_full), .tx_hold_write(tx_hold_write),
        .tx_xfer(tx_xfer), .rx_ie(rx_ie), .rx_wm_ie(rx_wm_ie), .rx_rdy_ie(rx_rdy_ie),
        .tx_ie(tx_ie), .tx_emp_ie(tx_emp_ie), .rx_ready(rx_ready), .tx_empty(tx_empty),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic check(string req, string what, logic [1:0] got, logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic check_all();
        for (int c = 0; c < 2; c++) begin
            check(tag_rdy[c], $sformatf("rx_ready[%0d]", c), {1'b0, rx_ready[c]}, {1'b0, m_rdy[c]});
            check(tag_emp[c], $sformatf("tx_empty[%0d]", c), {1'b0, tx_empty[c]}, {1'b0, m_emp[c]});
        end
        check("R8", "rx_irq", {1'b0, rx_irq}, {1'b0, m_rxi});
        check("R9", "tx_irq", {1'b0, tx_irq}, {1'b0, m_txi});
    endtask

    // Model: next state from the requirements, using the inputs now applied.
    task automatic model_next(output logic [1:0] nr, output logic [1:0] ne,
                              output logic nrx, output logic ntx);
        nrx = 1'b0; ntx = 1'b0;
        for (int c = 0; c < 2; c++) begin
            bit on = (c == 0) || two_ch_en;
            bit rset = rx_fifo_en[c] ? rx_fifo_load[c] : rx_hold_load[c];
            bit rclr = rx_fifo_en[c] ? rx_fifo_empty[c] : rx_hold_read[c];
            if (!on)       nr[c] = 1'b0;            // R7
            else if (rset) nr[c] = 1'b1;            // R2/R3, R6 set wins
            else if (rclr) nr[c] = 1'b0;
            else           nr[c] = m_rdy[c];
            if (!on)                ne[c] = 1'b0;   // R7
            else if (tx_fifo_en[c]) ne[c] = !tx_fifo_full[c];   // R4
            else if (tx_xfer[c])    ne[c] = 1'b1;   // R5, R6
            else if (tx_hold_write[c]) ne[c] = 1'b0;
            else                    ne[c] = m_emp[c];
            if (on && rx_ie && (rx_fifo_en[c] ? (rx_wm_ie[c] && rx_fifo_wm[c])
                                              : (rx_rdy_ie[c] && m_rdy[c]))) nrx = 1'b1;
            if (on && tx_ie && tx_emp_ie[c] &&
                (m_emp[c] || (!tx_fifo_en[c] && tx_xfer[c]))) ntx = 1'b1;
            tag_rdy[c] = !on ? "R7" : (rset && rclr) ? "R6" : rx_fifo_en[c] ? "R2" : "R3";
            tag_emp[c] = !on ? "R7" : tx_fifo_en[c] ? "R4" :
                         (tx_xfer[c] && tx_hold_write[c]) ? "R6" : "R5";
        end
        if (blk_rst) begin
            nr = '0; ne = '0; nrx = 1'b0; ntx = 1'b0;
            for (int c = 0; c < 2; c++) begin tag_rdy[c] = "R1"; tag_emp[c] = "R1"; end
        end
    endtask

    // inputs already applied (2 ns after an edge): advance one clock, update model
    task automatic cyc();
        logic [1:0] nr, ne;
        logic nrx, ntx;
        model_next(nr, ne, nrx, ntx);
        @(posedge clk);
        #2;
        m_rdy = nr; m_emp = ne; m_rxi = nrx; m_txi = ntx;
        check_all();
    endtask

    task automatic idle();
        blk_rst = 0; rx_fifo_load = '0; rx_fifo_empty = '0; rx_fifo_wm = '0;
        rx_hold_load = '0; rx_hold_read = '0; tx_fifo_full = '0;
        tx_hold_write = '0; tx_xfer = '0;
    endtask

    task automatic randomize_inputs();
        blk_rst       = ($urandom % 40) == 0;
        two_ch_en     = ($urandom % 4) != 0;
        rx_fifo_en    = $urandom; tx_fifo_en = $urandom;
        rx_fifo_load  = $urandom; rx_fifo_empty = $urandom; rx_fifo_wm = $urandom;
        rx_hold_load  = $urandom; rx_hold_read = $urandom; tx_fifo_full = $urandom;
        tx_hold_write = $urandom; tx_xfer = $urandom;
        rx_ie = $urandom; tx_ie = $urandom;
        rx_wm_ie = $urandom; rx_rdy_ie = $urandom; tx_emp_ie = $urandom;
    endtask

    task automatic por_pulse();
        por_n = 1'b0;
        #1;
        m_rdy = '0; m_emp = '0; m_rxi = 1'b0; m_txi = 1'b0;
        check("R1", "por rx_ready", rx_ready, 2'b00);
        check("R1", "por tx_empty", tx_empty, 2'b00);
        check("R1", "por irqs", {rx_irq, tx_irq}, 2'b00);
        @(posedge clk);
        #2;
        por_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < 2; c++) begin tag_rdy[c] = "R1"; tag_emp[c] = "R1"; end
        repeat (3) @(posedge clk);
        #2;
        check("R1", "reset rx_ready", rx_ready, 2'b00);
        check("R1", "reset tx_empty", tx_empty, 2'b00);
        check("R1", "reset irqs", {rx_irq, tx_irq}, 2'b00);
        por_n = 1'b1;

        // R3 / R10: hold load on ch0 -> flag after 1 clock, irq after 2
        rx_ie = 1; rx_rdy_ie = 2'b01; rx_hold_load = 2'b01;
        cyc();
        check("R10", "flag one clock after load", {rx_ready[0], rx_irq}, 2'b10);
        idle();
        cyc();
        check("R10", "irq two clocks after load", {rx_ready[0], rx_irq}, 2'b11);

        // R6: load and read together keep the flag set
        rx_hold_load = 2'b01; rx_hold_read = 2'b01;
        cyc();
        check("R6", "coincident load/read", {1'b0, rx_ready[0]}, 2'b01);
        idle(); rx_hold_read = 2'b01;
        cyc();
        check("R3", "read clears", {1'b0, rx_ready[0]}, 2'b00);

        // R7: single-channel mode ignores channel 1 events
        idle(); two_ch_en = 0; rx_hold_load = 2'b10; tx_xfer = 2'b10;
        tx_ie = 1; tx_emp_ie = 2'b10;
        cyc();
        idle();
        cyc();
        check("R7", "ch1 flags gated", {rx_ready[1], tx_empty[1]}, 2'b00);
        check("R7", "ch1 no tx irq", {1'b0, tx_irq}, 2'b00);

        // R2 and R4 in FIFO mode on ch1
        two_ch_en = 1; rx_fifo_en = 2'b10; tx_fifo_en = 2'b10; rx_fifo_load = 2'b10;
        cyc();
        check("R2", "fifo load sets ch1", {1'b0, rx_ready[1]}, 2'b01);
        check("R4", "tx fifo not full", {1'b0, tx_empty[1]}, 2'b01);
        idle(); rx_fifo_empty = 2'b10; tx_fifo_full = 2'b10;
        cyc();
        check("R2", "fifo empty clears ch1", {1'b0, rx_ready[1]}, 2'b00);
        check("R4", "tx fifo full clears", {1'b0, tx_empty[1]}, 2'b00);

        // R1: block reset overrides set events
        idle(); blk_rst = 1; rx_hold_load = 2'b01; rx_fifo_en = 2'b00;
        cyc();
        check("R1", "blk_rst priority", rx_ready, 2'b00);
        idle();

        // random phase with occasional power-on reset
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 250) == 0) begin
                por_pulse();
                for (int c = 0; c < 2; c++) begin tag_rdy[c] = "R1"; tag_emp[c] = "R1"; end
            end
            randomize_inputs();
            cyc();
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule